// File: doc/BRIEF.md
# Hybrid Rate-Multiplier / Pulse-Width Tuning DAC

This block turns a 13-bit tuning code into a one-bit pulse stream. A low-pass filter outside the block turns that stream into a tuning voltage for a varicap. Each conversion frame is 8192 clocks long. It is cut into 256 slots of 32 clocks each. The upper five code bits set a base pulse width that every slot carries. The lower eight bits drive a rate multiplier. That multiplier picks which slots get one more clock of pulse. So the number of active clocks in a frame equals the code.

At small codes the pulse count grows while each pulse stays one clock wide. Once the code reaches 256, every slot holds a pulse, and higher codes only make the pulses wider. The multiplier spreads the widened slots evenly over the frame: a slot is picked when its bit-reversed index is below the low code byte.

A new code is captured on a load strobe and held as pending. It becomes the active code only at a frame boundary, so no frame ever mixes two codes. The output is an enable for an open-drain pull-down: high means the pin is pulled to ground.

Top module: `tune_pwm_dac`

## Requirements
- R1: While reset is asserted, pull_dn is 0. The first clock edge after reset release starts a frame at slot 0, offset 0, with an active code of 0.
- R2: A frame is 8192 clocks: 256 slots of 32 clocks each. In a frame with active code C, pull_dn is 1 in exactly C clocks.
- R3: In each slot, pull_dn is 1 from offset 0 for one contiguous run, then 0 for the rest of the slot. The run is either B or B+1 clocks long, where B is code bits [12:8].
- R4: Slot s, for s from 0 to 255, gets the extra clock exactly when the 8-bit bit reversal of s is less than code bits [7:0].
- R5: For codes below 7936, the number of 0-to-1 transitions of pull_dn within a frame is min(C, 256).
- R6: A load strobe captures code_in as the pending code. The active code changes only at the last clock of a frame, where it takes the pending value held before that edge. If several loads occur within a frame, the last one wins. A load on a frame's final clock first takes effect one frame later.
- R7: Code 0 gives no active clock. Code 8191 keeps pull_dn at 1 for every clock of the frame except the final clock of slot 255.
- R8: With no load strobe, the active code repeats unchanged frame after frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures code_in as the pending code |
| code_in | input | 13 | Tuning code |
| pull_dn | output | 1 | Pull-down enable: 1 means the output is pulled to ground |

## Verification
A stuck or skipped frame counter shows up at the next slot boundary. Pulses then start at the wrong offset or slots grow longer than 32 clocks. The per-clock pattern check sees this within one slot. A wrong bit reversal in the rate multiplier keeps the frame total correct but moves the extra clocks to other slots, so only the per-slot comparison catches it within the frame. A code swap at the wrong moment damages the frame in progress, which shows as a mismatch inside that frame and a wrong total at its end.

// File: rtl/tune_dac_pkg.sv
package tune_dac_pkg;
  localparam int unsigned DAC_CODE_W = 13;
  localparam int unsigned DAC_SLOT_BITS = 8;

  // Length of the active run in one slot: base width plus the optional extra clock.
  function automatic logic [15:0] run_length(input logic [15:0] base, input logic extra);
    return base + {15'd0, extra};
  endfunction

  // True while the in-slot offset still lies inside the active run.
  function automatic logic run_active(input logic [15:0] offset, input logic [15:0] len);
    return offset < len;
  endfunction
endpackage

// File: rtl/tune_frame_ctr.sv
module tune_frame_ctr #(
  parameter int unsigned SLOT_BITS = 8,
  parameter int unsigned POS_BITS  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [SLOT_BITS-1:0] slot_idx,
  output logic [POS_BITS-1:0]  slot_pos,
  output logic                 frame_end
);
  localparam int unsigned CNT_W = SLOT_BITS + POS_BITS;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end

  assign slot_idx  = count[CNT_W-1:POS_BITS];
  assign slot_pos  = count[POS_BITS-1:0];
  assign frame_end = &count;
endmodule

// File: rtl/tune_rate_mult.sv
module tune_rate_mult #(
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic [SLOT_BITS-1:0] slot_idx,
  input  logic [SLOT_BITS-1:0] frac,
  output logic                 extra_slot
);
  logic [SLOT_BITS-1:0] rev_idx;

  for (genvar i = 0; i < SLOT_BITS; i++) begin : g_rev
    assign rev_idx[i] = slot_idx[SLOT_BITS-1-i];
  end

  assign extra_slot = rev_idx < frac;
endmodule

// File: rtl/tune_pulse_shaper.sv
module tune_pulse_shaper #(
  parameter int unsigned POS_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [POS_BITS-1:0] slot_pos,
  input  logic [POS_BITS-1:0] base_width,
  input  logic                extra_slot,
  output logic                pull_dn
);
  import tune_dac_pkg::*;

  logic [15:0] run_len;
  logic        run_now;

  always_comb begin
    run_len = run_length(16'(base_width), extra_slot);
    run_now = run_active(16'(slot_pos), run_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_dn <= 1'b0;
    else        pull_dn <= run_now;
  end
endmodule

// File: rtl/tune_pwm_dac.sv
module tune_pwm_dac #(
  parameter int unsigned CODE_W    = 13,
  parameter int unsigned SLOT_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic              pull_dn
);
  localparam int unsigned POS_BITS = CODE_W - SLOT_BITS;

  logic [CODE_W-1:0]    pend_code;
  logic [CODE_W-1:0]    active_code;
  logic [SLOT_BITS-1:0] slot_idx;
  logic [POS_BITS-1:0]  slot_pos;
  logic                 frame_end;
  logic                 extra_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_code <= '0;
    else if (load) pend_code <= code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_code <= '0;
    else if (frame_end) active_code <= pend_code;
  end

  tune_frame_ctr #(.SLOT_BITS(SLOT_BITS), .POS_BITS(POS_BITS)) i_ctr (
    .clk(clk), .rst_n(rst_n),
    .slot_idx(slot_idx), .slot_pos(slot_pos), .frame_end(frame_end)
  );

  tune_rate_mult #(.SLOT_BITS(SLOT_BITS)) i_rate (
    .slot_idx(slot_idx), .frac(active_code[SLOT_BITS-1:0]), .extra_slot(extra_slot)
  );

  tune_pulse_shaper #(.POS_BITS(POS_BITS)) i_shape (
    .clk(clk), .rst_n(rst_n), .slot_pos(slot_pos),
    .base_width(active_code[CODE_W-1:SLOT_BITS]), .extra_slot(extra_slot),
    .pull_dn(pull_dn)
  );
endmodule

// File: rtl/tune_dac_checker.sv
module tune_dac_checker #(
  parameter int unsigned CODE_W    = 13,
  parameter int unsigned SLOT_BITS = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          load,
  input logic [CODE_W-1:0]             code_in,
  input logic [CODE_W-1:0]             pend_code,
  input logic [CODE_W-1:0]             active_code,
  input logic [SLOT_BITS-1:0]          slot_idx,
  input logic [CODE_W-SLOT_BITS-1:0]   slot_pos,
  input logic                          frame_end,
  input logic                          pull_dn
);
  localparam int unsigned POS_BITS = CODE_W - SLOT_BITS;

  logic [POS_BITS-1:0] base_w;
  assign base_w = active_code[CODE_W-1:SLOT_BITS];

  // R2: the counter wraps to slot 0, offset 0 after the last clock
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (slot_idx == '0 && slot_pos == '0));

  // R3: offsets below the base width are always active
  p_base_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pos < base_w) |=> pull_dn);

  // R3: offsets beyond base width plus one are never active
  p_base_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_pos > base_w) |=> !pull_dn);

  // R7: code zero keeps the output released
  p_zero_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_code == '0) |=> !pull_dn);

  // R6: the active code holds inside a frame
  p_hold_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(active_code));

  // R6: a load strobe captures the input
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pend_code == $past(code_in)));

  // R6: the pending code moves to active at the frame boundary
  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (active_code == $past(pend_code)));
endmodule

bind tune_pwm_dac tune_dac_checker #(.CODE_W(CODE_W), .SLOT_BITS(SLOT_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .code_in(code_in),
  .pend_code(pend_code), .active_code(active_code),
  .slot_idx(slot_idx), .slot_pos(slot_pos), .frame_end(frame_end),
  .pull_dn(pull_dn)
);

// File: tb/test_tune_pwm_dac.sv
module test_tune_pwm_dac;
  localparam int FRAME = 8192;
  localparam int NFRAMES = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [12:0] code_in = '0;
  logic        pull_dn;

  int checks = 0;
  int fails = 0;
  int e = -1;
  int frames_done = 0;
  int unsigned cur_code = 0;
  int unsigned pend = 0;
  int fsum, fedge, fmis, first_pos;
  bit prev;
  bit done = 1'b0;

  tune_pwm_dac i_tune_pwm_dac (
    .clk(clk), .rst_n(rst_n), .load(load), .code_in(code_in), .pull_dn(pull_dn)
  );

  always #2 clk = ~clk;

  // Expected output for a given code at a given clock of the frame.
  function automatic bit exp_bit(input int unsigned code, input int pos);
    int slot, off, rv, hi, lo, w;
    slot = pos / 32;
    off  = pos % 32;
    rv = 0;
    for (int b = 0; b < 8; b++) if (((slot >> b) & 1) != 0) rv += (1 << (7 - b));
    hi = int'(code) / 256;
    lo = int'(code) % 256;
    w = hi + ((rv < lo) ? 1 : 0);
    return off < w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Model and sampler, run just after each active edge.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      int pos;
      bit expb;
      e++;
      pos = e % FRAME;
      if (pos == 0) begin fsum = 0; fedge = 0; fmis = 0; prev = 1'b0; first_pos = 0; end
      expb = exp_bit(cur_code, pos);
      if (pull_dn) fsum++;
      if (pull_dn && !prev) fedge++;
      prev = pull_dn;
      if (pull_dn !== expb) begin
        if (fmis == 0) first_pos = pos;
        fmis++;
      end
      if (pos == FRAME - 1) begin
        // R3 R4 R6: per-clock pattern matches the code chosen at the boundary
        check(fmis == 0, $sformatf("R3 R4 R6 pattern code=%0d first_bad_pos=%0d", cur_code, first_pos),
              fmis, 0);
        // R2 R8: active clocks per frame equal the code
        check(fsum == int'(cur_code), "R2 R8 active clocks per frame", fsum, int'(cur_code));
        if (cur_code < 7936) begin
          // R5: pulse count saturates at 256
          check(fedge == ((cur_code < 256) ? int'(cur_code) : 256), "R5 pulses per frame",
                fedge, (cur_code < 256) ? int'(cur_code) : 256);
        end
        if (cur_code == 0 || cur_code == 8191) begin
          // R7: extreme codes
          check(fsum == int'(cur_code) && fmis == 0, "R7 extreme code total", fsum, int'(cur_code));
        end
        frames_done++;
        cur_code = pend;
      end
      if (load) pend = code_in;
    end
  end

  task automatic load_at(input int t, input int unsigned c);
    @(negedge clk);
    while (e < t - 1) @(negedge clk);
    load = 1'b1;
    code_in = 13'(c);
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(negedge clk);
    // R1: output released during reset
    check(pull_dn == 1'b0, "R1 output during reset", int'(pull_dn), 0);
    @(negedge clk);
    check(pull_dn == 1'b0, "R1 output during reset", int'(pull_dn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: first clock after release is offset 0 of a code-0 frame
    check(pull_dn == 1'b0, "R1 first clock after release", int'(pull_dn), 0);
    for (int f = 0; f < NFRAMES - 1; f++) begin
      int base;
      int t;
      base = f * FRAME;
      t = 100 + int'($urandom % 7900);
      case (f)
        0:  load_at(base + t, 1);
        1:  load_at(base + t, 8191);
        2:  ;                                   // R8: frame 3 repeats 8191
        3:  load_at(base + t, 0);
        4:  load_at(base + t, 255);
        5:  load_at(base + t, 256);
        6:  load_at(base + t, 257);
        7:  load_at(base + t, 7935);
        8:  load_at(base + t, 4096);
        9:  begin                                // R6: last load wins
              load_at(base + 200, $urandom % 8192);
              load_at(base + 6000, 128);
            end
        11: load_at(base + FRAME - 1, $urandom % 8192); // R6: load on final clock
        12: ;
        default: load_at(base + t, $urandom % 8192);
      endcase
    end
    wait (frames_done == NFRAMES);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d frames", frames_done, NFRAMES);
    finish_run();
  end
endmodule